// File: doc/BRIEF.md
# Register-Operand Integer ALU

This block is the combinational 32-bit arithmetic and logic unit of a small RISC core. Each evaluation takes a first operand, a second operand that an upstream shifter has already prepared, the carry flag, the shifter's carry-out, the destination register's current value and a 4-bit operation code. From these it produces a 32-bit result and a four-bit flag vector.

The unit covers add, add-with-carry, subtract, AND, OR, exclusive OR, bit clear, move, move-not and move-top. Move-top places a 16-bit value in the upper half of the destination and keeps the destination's existing lower half. Add-with-carry lets software build a wide sum one word at a time.

A flag-update enable chooses between two sources for the outgoing flags. When it is high they are the freshly computed values. When it is low they are the incoming flags, unchanged. The block holds no state.

Top module: `alu_core`

## Requirements
- R1: With op code 0 (add) the result is op_a + op_b modulo 2^32. C is the carry out of bit 31. V is set when both addends have the same sign and the result's sign differs from it.
- R2: With op code 1 (add-with-carry) the result is op_a + op_b + carry_in. Chaining works as follows: an add of the low words followed by an add-with-carry of the high words turns 0x00000000FFFFFFFF + 0x0000000100000001 into 0x0000000200000000.
- R3: With op code 2 (subtract) the result is op_a + ~op_b + 1. C is 1 exactly when no borrow occurs, that is when op_a >= op_b unsigned. V follows the R1 rule, applied to op_a and ~op_b.
- R4: Op codes 3, 4 and 5 give the full-width AND, OR and exclusive OR of op_a and op_b. For example, 0xFFFF3333 AND 0xFF00FF00 = 0xFF003300, and 0x000000FF XOR 0x0000FF00 = 0x0000FFFF.
- R5: With op code 6 (bit clear) the result is op_a AND NOT op_b. For example, 0x0000FFFF with mask 0x0F gives 0x0000FFF0.
- R6: Op code 7 (move) writes op_b unchanged. Op code 8 (move-not) writes ~op_b, so 0x0 gives 0xFFFFFFFF and 0x0F gives 0xFFFFFFF0.
- R7: With op code 9 (move-top) the result is {op_b[15:0], dst_old[15:0]}. For example, 0x0000FFFF with value 0xEEEE gives 0xEEEEFFFF.
- R8: The flag vector is laid out as [3]=N, [2]=Z, [1]=C, [0]=V. When new flags are taken, N is result bit 31 and Z is 1 exactly when the result is zero.
- R9: For op codes 3 to 9 with set_flags high, C is taken from shift_carry and V is copied from flags_in[0].
- R10: With set_flags low, flags_out equals flags_in for every op code, and the result is still produced.
- R11: Op codes 10 to 15 have no effect. The result equals dst_old, and flags_out equals flags_in whatever set_flags is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 32 | First operand |
| op_b | input | 32 | Prepared second operand |
| dst_old | input | 32 | Current destination value |
| op_sel | input | 4 | Operation code |
| carry_in | input | 1 | Carry flag consumed by add-with-carry |
| shift_carry | input | 1 | Shifter carry-out, used as C by logical ops |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| set_flags | input | 1 | 1: take new flags, 0: pass flags_in through |
| result | output | 32 | Operation result |
| flags_out | output | 4 | Outgoing flags {N,Z,C,V} |

## Verification
Two things can happen in the same evaluation: the arithmetic produces a carry or overflow, and the flag-update enable is low and discards it. The bench provokes this with a signed-overflowing add that has set_flags cleared. It judges the outcome by requiring the full sum on result while flags_out repeats flags_in bit for bit. A related pairing is the logical ops: the result comes from the operands, C comes from the shifter input, and V must survive from the old flags. Those cases use flag inputs whose values differ from what an arithmetic update would write.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int unsigned OP_W   = 4;
  localparam int unsigned FLAG_W = 4;

  // Flag vector positions
  localparam int unsigned FN = 3;
  localparam int unsigned FZ = 2;
  localparam int unsigned FC = 1;
  localparam int unsigned FV = 0;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_AND  = 4'd3,
    OP_ORR  = 4'd4,
    OP_EOR  = 4'd5,
    OP_BIC  = 4'd6,
    OP_MOV  = 4'd7,
    OP_MVN  = 4'd8,
    OP_MOVT = 4'd9
  } alu_op_e;

  function automatic logic op_is_arith(input logic [OP_W-1:0] op);
    return (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB);
  endfunction

  function automatic logic op_is_logic(input logic [OP_W-1:0] op);
    return (op >= OP_AND) && (op <= OP_MOVT);
  endfunction

endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         invert_b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         carry,
  output logic         ovf
);

  logic [W-1:0] b_eff;
  logic [W:0]   wide;

  function automatic logic [W:0] add_wide(input logic [W-1:0] x,
                                          input logic [W-1:0] y,
                                          input logic         c);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  function automatic logic signed_ovf(input logic xs, input logic ys,
                                      input logic rs);
    return (xs == ys) && (rs != xs);
  endfunction

  always_comb begin
    b_eff = invert_b ? ~b : b;
    wide  = add_wide(a, b_eff, cin);
    sum   = wide[W-1:0];
    carry = wide[W];
    ovf   = signed_ovf(a[W-1], b_eff[W-1], wide[W-1]);
  end

  // R3: subtract yielding zero means equal operands
  always_comb begin
    if (!$isunknown({a, b, invert_b, cin}) && invert_b && cin && (sum == '0))
      p_sub_zero_equal_r3: assert (a == b && carry);
  end

endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic [W-1:0]    dst_old,
  output logic [W-1:0]    res
);

  localparam int unsigned HALF = W / 2;

  function automatic logic [W-1:0] place_top(input logic [W-1:0] imm,
                                             input logic [W-1:0] old);
    return {imm[HALF-1:0], old[HALF-1:0]};
  endfunction

  always_comb begin
    unique case (op)
      OP_AND:  res = a & b;
      OP_ORR:  res = a | b;
      OP_EOR:  res = a ^ b;
      OP_BIC:  res = a & ~b;
      OP_MOV:  res = b;
      OP_MVN:  res = ~b;
      OP_MOVT: res = place_top(b, dst_old);
      default: res = dst_old;
    endcase
  end

  // R7: move-top keeps the low half of the destination
  always_comb begin
    if (!$isunknown({op, dst_old, b}) && op == OP_MOVT)
      p_movt_low_kept_r7: assert (res[HALF-1:0] == dst_old[HALF-1:0]
                                  && res[W-1:HALF] == b[HALF-1:0]);
  end

endmodule

// File: rtl/alu_flags.sv
module alu_flags
  import alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]      res,
  input  logic              is_arith,
  input  logic              is_logic,
  input  logic              add_carry,
  input  logic              add_ovf,
  input  logic              shift_carry,
  input  logic [FLAG_W-1:0] flags_in,
  input  logic              set_flags,
  output logic [FLAG_W-1:0] flags_out
);

  logic [FLAG_W-1:0] fresh;
  logic              take_new;

  always_comb begin
    take_new  = set_flags && (is_arith || is_logic);
    fresh[FN] = res[W-1];
    fresh[FZ] = (res == '0);
    fresh[FC] = is_arith ? add_carry : shift_carry;
    fresh[FV] = is_arith ? add_ovf   : flags_in[FV];
    flags_out = take_new ? fresh : flags_in;
  end

  // R9: logical ops never alter V
  always_comb begin
    if (!$isunknown({is_logic, flags_in, flags_out}) && is_logic)
      p_logic_v_kept_r9: assert (flags_out[FV] == flags_in[FV]);
  end

  // R8: Z, when freshly taken, agrees with the result
  always_comb begin
    if (!$isunknown({res, take_new}) && take_new)
      p_zero_flag_r8: assert (flags_out[FZ] == (res == '0)
                              && flags_out[FN] == res[W-1]);
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]      op_a,
  input  logic [W-1:0]      op_b,
  input  logic [W-1:0]      dst_old,
  input  logic [OP_W-1:0]   op_sel,
  input  logic              carry_in,
  input  logic              shift_carry,
  input  logic [FLAG_W-1:0] flags_in,
  input  logic              set_flags,
  output logic [W-1:0]      result,
  output logic [FLAG_W-1:0] flags_out
);

  logic         is_arith;
  logic         is_logic;
  logic         is_sub;
  logic         add_cin;
  logic [W-1:0] add_sum;
  logic         add_carry;
  logic         add_ovf;
  logic [W-1:0] logic_res;

  always_comb begin
    is_arith = op_is_arith(op_sel);
    is_logic = op_is_logic(op_sel);
    is_sub   = (op_sel == OP_SUB);
    unique case (op_sel)
      OP_SUB:  add_cin = 1'b1;
      OP_ADC:  add_cin = carry_in;
      default: add_cin = 1'b0;
    endcase
  end

  alu_adder #(.W(W)) i_adder (
    .a        (op_a),
    .b        (op_b),
    .invert_b (is_sub),
    .cin      (add_cin),
    .sum      (add_sum),
    .carry    (add_carry),
    .ovf      (add_ovf)
  );

  alu_logic #(.W(W)) i_logic (
    .op      (op_sel),
    .a       (op_a),
    .b       (op_b),
    .dst_old (dst_old),
    .res     (logic_res)
  );

  always_comb begin
    result = is_arith ? add_sum : logic_res;
  end

  alu_flags #(.W(W)) i_flags (
    .res         (result),
    .is_arith    (is_arith),
    .is_logic    (is_logic),
    .add_carry   (add_carry),
    .add_ovf     (add_ovf),
    .shift_carry (shift_carry),
    .flags_in    (flags_in),
    .set_flags   (set_flags),
    .flags_out   (flags_out)
  );

  // R10: flags hold when the update enable is low
  always_comb begin
    if (!$isunknown({set_flags, flags_in, flags_out}) && !set_flags)
      p_flags_hold_r10: assert (flags_out == flags_in);
  end

  // R11: unused op codes leave destination and flags alone
  always_comb begin
    if (!$isunknown({op_sel, dst_old, flags_in}) && op_sel > OP_MOVT)
      p_unused_noop_r11: assert (result == dst_old && flags_out == flags_in);
  end

endmodule

// File: tb/test_alu_core.sv
module test_alu_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] op_a, op_b, dst_old;
  logic [3:0]  op_sel;
  logic        carry_in, shift_carry, set_flags;
  logic [3:0]  flags_in;
  logic [31:0] result;
  logic [3:0]  flags_out;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  typedef struct {
    logic [31:0] res;
    logic [3:0]  flg;
    string       tag;
  } exp_t;

  exp_t sb[$];

  always #10 clk = ~clk;  // 50 MHz

  alu_core i_alu_core (
    .op_a(op_a), .op_b(op_b), .dst_old(dst_old), .op_sel(op_sel),
    .carry_in(carry_in), .shift_carry(shift_carry), .flags_in(flags_in),
    .set_flags(set_flags), .result(result), .flags_out(flags_out)
  );

  // Reference model written from the requirements, using 64-bit arithmetic
  function automatic exp_t model(input logic [3:0] op, input logic [31:0] a,
                                 input logic [31:0] b, input logic [31:0] old,
                                 input logic ci, input logic sc,
                                 input logic [3:0] fi, input logic sf);
    exp_t e;
    longint ua, ub, s;
    longint sa, sb2, ss;
    logic c, v, arith, known;
    ua = longint'(a); ub = longint'(b);
    sa = longint'($signed(a)); sb2 = longint'($signed(b));
    arith = 0; known = 1; c = sc; v = fi[0];
    case (op)
      4'd0: begin s = ua + ub; ss = sa + sb2; arith = 1; end
      4'd1: begin s = ua + ub + longint'(ci); ss = sa + sb2 + longint'(ci); arith = 1; end
      4'd2: begin s = ua - ub; ss = sa - sb2; arith = 1; end
      4'd3: e.res = a & b;
      4'd4: e.res = a | b;
      4'd5: e.res = a ^ b;
      4'd6: e.res = a & ~b;
      4'd7: e.res = b;
      4'd8: e.res = ~b;
      4'd9: e.res = {b[15:0], old[15:0]};
      default: begin e.res = old; known = 0; end
    endcase
    if (arith) begin
      e.res = s[31:0];
      c = (op == 4'd2) ? (ua >= ub) : (s > 64'sh0FFFFFFFF);
      v = (ss > 64'sh07FFFFFFF) || (ss < -64'sh080000000);
    end
    if (sf && known) e.flg = {e.res[31], e.res == 32'h0, c, v};
    else             e.flg = fi;
    return e;
  endfunction

  task automatic drive(input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] old,
                       input logic ci, input logic sc, input logic [3:0] fi,
                       input logic sf, input string tag);
    exp_t e;
    @(posedge clk);
    #2;
    op_sel = op; op_a = a; op_b = b; dst_old = old;
    carry_in = ci; shift_carry = sc; flags_in = fi; set_flags = sf;
    e = model(op, a, b, old, ci, sc, fi, sf);
    e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: compares at the falling edge, after inputs have settled
  initial begin
    forever begin
      exp_t e;
      @(negedge clk);
      if (!rst && sb.size() > 0) begin
        e = sb.pop_front();
        checks++;
        if (result !== e.res) begin
          failures++;
          $display("FAIL %s result actual=%h expected=%h", e.tag, result, e.res);
        end
        checks++;
        if (flags_out !== e.flg) begin
          failures++;
          $display("FAIL %s flags actual=%b expected=%b", e.tag, flags_out, e.flg);
        end
      end
    end
  end

  initial begin
    #4_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    op_sel = 0; op_a = 0; op_b = 0; dst_old = 0; carry_in = 0;
    shift_carry = 0; flags_in = 0; set_flags = 0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // Quiet state: all-zero inputs, flags taken -> Z only (R8)
    drive(4'd0, 0, 0, 0, 0, 0, 4'b0000, 1, "R8 zero state");
    // R1 add
    drive(4'd0, 32'd10, 32'd1, 0, 0, 0, 4'b0000, 1, "R1 add small");
    drive(4'd0, 32'h7FFFFFFF, 32'd1, 0, 0, 0, 4'b0000, 1, "R1 add signed ovf");
    drive(4'd0, 32'hFFFFFFFF, 32'd1, 0, 0, 0, 4'b0000, 1, "R1 add carry out");
    drive(4'd0, 32'h80000000, 32'h80000000, 0, 0, 0, 4'b0000, 1, "R1 add neg ovf");
    // R2 64-bit chain: low words, then high words with carry
    drive(4'd0, 32'hFFFFFFFF, 32'h00000001, 0, 0, 0, 4'b0000, 1, "R2 low word");
    drive(4'd1, 32'h00000000, 32'h00000001, 0, 1, 0, 4'b0010, 1, "R2 high word");
    drive(4'd1, 32'd5, 32'd6, 0, 0, 0, 4'b0000, 1, "R2 adc no carry");
    // R3 subtract
    drive(4'd2, 32'd10, 32'd1, 0, 0, 0, 4'b0000, 1, "R3 sub no borrow");
    drive(4'd2, 32'd1, 32'd10, 0, 0, 0, 4'b0000, 1, "R3 sub borrow");
    drive(4'd2, 32'd5, 32'd5, 0, 1, 0, 4'b0000, 1, "R3 sub equal");
    drive(4'd2, 32'h80000000, 32'd1, 0, 0, 0, 4'b0000, 1, "R3 sub ovf");
    // R4 bitwise
    drive(4'd3, 32'hFFFF3333, 32'hFF00FF00, 0, 0, 1, 4'b0001, 1, "R4 and");
    drive(4'd4, 32'h0, 32'hF, 0, 0, 0, 4'b0000, 1, "R4 orr");
    drive(4'd5, 32'h000000FF, 32'h0000FF00, 0, 0, 0, 4'b0000, 1, "R4 eor");
    // R5 bit clear
    drive(4'd6, 32'h0000FFFF, 32'h0F, 0, 0, 1, 4'b0000, 1, "R5 bic");
    // R6 moves
    drive(4'd7, 32'h12345678, 32'h0000FFFF, 0, 0, 0, 4'b0000, 1, "R6 mov");
    drive(4'd8, 32'h0, 32'h0, 0, 0, 0, 4'b0000, 1, "R6 mvn zero");
    drive(4'd8, 32'h0, 32'h0F, 0, 0, 1, 4'b0001, 1, "R6 mvn mask");
    // R7 move-top
    drive(4'd9, 32'hDEADBEEF, 32'h0000EEEE, 32'h0000FFFF, 0, 0, 4'b0000, 1, "R7 movt");
    drive(4'd9, 32'h0, 32'hABCD0000, 32'h5555AAAA, 0, 0, 4'b0000, 1, "R7 movt zero top");
    // R9 logical: C from shifter, V retained
    drive(4'd3, 32'h0, 32'hFFFFFFFF, 0, 0, 1, 4'b0001, 1, "R9 and zero keep V");
    drive(4'd4, 32'h1, 32'h2, 0, 1, 0, 4'b0011, 1, "R9 orr C from shift");
    // R10 flags pass through while an overflowing add is computed
    drive(4'd0, 32'h7FFFFFFF, 32'd1, 0, 0, 0, 4'b0110, 0, "R10 add no update");
    drive(4'd2, 32'd3, 32'd3, 0, 0, 0, 4'b1001, 0, "R10 sub no update");
    // R11 unused op codes
    drive(4'd10, 32'h1, 32'h2, 32'hCAFEF00D, 1, 1, 4'b1010, 1, "R11 op10");
    drive(4'd15, 32'hFFFFFFFF, 32'h1, 32'h00000000, 0, 0, 4'b0101, 1, "R11 op15");
    repeat (3) @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule